// File: doc/BRIEF.md
# Memory operation ordering queue

This block holds the memory operations that dispatch has handed to the back end. It keeps them in program order across two separate pools, one for reads and one for writes. Every cycle it presents, for each occupied slot, whether that operation may be issued under a relaxed ordering model. There is no address comparison. Instead a fixed set of rules applies, together with a single global switch that lets reads pass older writes. Operations with side effects are held as soft barriers. A barrier occupies a slot and leaves by itself once nothing older remains in the pool or pools it sits in.

Dispatch offers one operation per cycle on a valid/ready handshake. The operation is described by three flags: reads memory, writes memory, has side effects. `alloc_ready` depends on the offered flags. The source must hold valid and flags steady until ready is seen, and the operation is taken on the clock edge where both are high. At that handshake the block reports the slot or slots it used. The back end later names a slot on the completion inputs, which have no back-pressure. The block reports the slots freed each cycle back to dispatch as credit counts. Each pool has a depth parameter, and a depth of zero selects the maximum-depth parameter.

Top module: `lsq_order_unit`

## Requirements
- R1: A store slot is issue-eligible only when no slot in the store pool (store or barrier) holds an older operation, so at most one store is eligible at a time.
- R2: A store is never eligible while an older load occupies the load pool, whatever the value of `noalias`.
- R3: A load may be eligible ahead of an older, still-present load only when no store and no barrier is younger than that load and older than itself.
- R4: A load that has an older store present is eligible only while `noalias` is 1. Changing `noalias` affects eligibility in the same cycle.
- R5: A load barrier or full barrier keeps every younger load ineligible, and a store barrier or full barrier keeps every younger store ineligible, until the barrier leaves its pool.
- R6: A barrier is never issue-eligible. A load barrier or store barrier frees its slot on the first clock edge at which no older slot exists in its own pool. A full barrier frees both of its slots on the first edge at which no older slot exists in either pool.
- R7: The flags are classified as follows. A side-effect op with both read and write is a full barrier, taking one load slot and one store slot. A side-effect op with read only is a load barrier in the load pool. A side-effect op with write only is a store barrier in the store pool. A plain op with write set is a store, whether or not read is also set. A plain op with read only is a load. An op with neither read nor write occupies nothing.
- R8: A pool depth parameter of 0 means `MAX_DEPTH` slots. The default configuration therefore has 4 load slots and 6 store slots. `lq_full`/`sq_full` are high exactly when the pool has no free slot. `alloc_ready` is low when a pool the offered op needs is full, and is 1 when nothing is offered. After reset both pools are empty and nothing is eligible.
- R9: A completion naming an occupied slot frees it at the next edge. In the cycle before the edge, `lq_credit_cnt`/`sq_credit_cnt` give the number of slots of that pool being freed, counting completions and barrier departures together.
- R10: A new op takes the lowest-numbered free slot of each pool it needs, and that index is shown on `alloc_lq_slot`/`alloc_sq_slot` during the handshake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noalias | input | 1 | 1: loads may pass older stores |
| alloc_valid | input | 1 | Dispatch offers an op |
| alloc_ld | input | 1 | Op reads memory |
| alloc_st | input | 1 | Op writes memory |
| alloc_sfx | input | 1 | Op has side effects |
| alloc_ready | output | 1 | Op can be taken this cycle |
| alloc_lq_slot | output | LQ_IW | Load slot used by the offered op |
| alloc_sq_slot | output | SQ_IW | Store slot used by the offered op |
| cmp_lq_valid | input | 1 | Load-pool completion |
| cmp_lq_slot | input | LQ_IW | Completed load slot |
| cmp_sq_valid | input | 1 | Store-pool completion |
| cmp_sq_slot | input | SQ_IW | Completed store slot |
| lq_issue_ok | output | LQ_N | Per-slot load eligibility |
| sq_issue_ok | output | SQ_N | Per-slot store eligibility |
| lq_full | output | 1 | Load pool has no free slot |
| sq_full | output | 1 | Store pool has no free slot |
| lq_credit_cnt | output | 2 | Load slots freed at the coming edge |
| sq_credit_cnt | output | 2 | Store slots freed at the coming edge |

## Verification
Two paths can free slots of the same pool in one cycle: a completion notice, and a barrier leaving because it has become the oldest entry. To provoke this, the bench places a load barrier between two loads and completes the older load. In the cycle where the barrier leaves, it also completes the younger load. The bench then expects a load credit count of 2 and an empty pool on the next cycle. It confirms the empty pool by refilling it and seeing `lq_full` rise after exactly four allocations.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_LOAD,
    K_STORE,
    K_LBAR,
    K_SBAR,
    K_FBAR
  } mem_kind_e;

  // Map the dispatch flags onto an entry kind.
  function automatic mem_kind_e classify(input logic ld, input logic st, input logic sfx);
    mem_kind_e k;
    if (sfx) begin
      if (ld && st)  k = K_FBAR;
      else if (ld)   k = K_LBAR;
      else if (st)   k = K_SBAR;
      else           k = K_NONE;
    end else begin
      if (st)        k = K_STORE;
      else if (ld)   k = K_LOAD;
      else           k = K_NONE;
    end
    return k;
  endfunction

endpackage

// File: rtl/lsq_pick.sv
module lsq_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan downward so the lowest free index wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lsq_queue.sv
module lsq_queue #(
  parameter int N     = 4,
  parameter int AGE_W = 6,
  parameter int IW    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [AGE_W-1:0]          wr_age,
  input  logic                      wr_bar,
  input  logic                      wr_full,
  input  logic [N-1:0]              clr,
  output logic [N-1:0]              vld,
  output logic [N-1:0][AGE_W-1:0]   age,
  output logic [N-1:0]              bar,
  output logic [N-1:0]              fullb
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
      end else if (hit) begin
        vld[g] <= 1'b1;
      end else if (clr[g]) begin
        vld[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age[g]   <= '0;
        bar[g]   <= 1'b0;
        fullb[g] <= 1'b0;
      end else if (hit) begin
        age[g]   <= wr_age;
        bar[g]   <= wr_bar;
        fullb[g] <= wr_full;
      end
    end
  end

  // A write only ever lands on an empty slot.
  p_slot_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !vld[wr_idx]);

  // A cleared live slot is empty afterwards.
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & vld)) |=> ((vld & $past(clr & vld)) == '0));

endmodule

// File: rtl/lsq_rules.sv
module lsq_rules #(
  parameter int LQN   = 4,
  parameter int SQN   = 6,
  parameter int AGE_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        noalias,
  input  logic [LQN-1:0]              lq_vld,
  input  logic [LQN-1:0][AGE_W-1:0]   lq_age,
  input  logic [LQN-1:0]              lq_bar,
  input  logic [LQN-1:0]              lq_fb,
  input  logic [SQN-1:0]              sq_vld,
  input  logic [SQN-1:0][AGE_W-1:0]   sq_age,
  input  logic [SQN-1:0]              sq_bar,
  input  logic [SQN-1:0]              sq_fb,
  output logic [LQN-1:0]              lq_ok,
  output logic [SQN-1:0]              sq_ok,
  output logic [LQN-1:0]              lq_ret,
  output logic [SQN-1:0]              sq_ret
);

  // a is older than b when a - b wraps negative.
  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  // Load pool: eligibility and barrier departure.
  always_comb begin
    for (int i = 0; i < LQN; i++) begin
      logic blk;
      logic old_lq;
      logic old_sq;
      blk    = 1'b0;
      old_lq = 1'b0;
      old_sq = 1'b0;
      for (int k = 0; k < LQN; k++) begin
        if (lq_vld[k] && older(lq_age[k], lq_age[i])) begin
          old_lq = 1'b1;
          if (lq_bar[k]) begin
            blk = 1'b1;
          end else begin
            for (int m = 0; m < SQN; m++) begin
              if (sq_vld[m] && older(lq_age[k], sq_age[m]) && older(sq_age[m], lq_age[i]))
                blk = 1'b1;
            end
          end
        end
      end
      for (int j = 0; j < SQN; j++) begin
        if (sq_vld[j] && older(sq_age[j], lq_age[i])) begin
          old_sq = 1'b1;
          if (!sq_bar[j] && !noalias) blk = 1'b1;
        end
      end
      lq_ok[i]  = lq_vld[i] && !lq_bar[i] && !blk;
      lq_ret[i] = lq_vld[i] && lq_bar[i] && !old_lq && (!lq_fb[i] || !old_sq);
    end
  end

  // Store pool: eligibility and barrier departure.
  always_comb begin
    for (int j = 0; j < SQN; j++) begin
      logic old_sq;
      logic old_lq;
      logic old_ld;
      old_sq = 1'b0;
      old_lq = 1'b0;
      old_ld = 1'b0;
      for (int m = 0; m < SQN; m++) begin
        if (sq_vld[m] && older(sq_age[m], sq_age[j])) old_sq = 1'b1;
      end
      for (int k = 0; k < LQN; k++) begin
        if (lq_vld[k] && older(lq_age[k], sq_age[j])) begin
          old_lq = 1'b1;
          if (!lq_bar[k]) old_ld = 1'b1;
        end
      end
      sq_ok[j]  = sq_vld[j] && !sq_bar[j] && !old_sq && !old_ld;
      sq_ret[j] = sq_vld[j] && sq_bar[j] && !old_sq && (!sq_fb[j] || !old_lq);
    end
  end

  // Stores leave strictly in order: never two eligible at once.
  p_one_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sq_ok) <= 1);

endmodule

// File: rtl/lsq_order_unit.sv
module lsq_order_unit
  import lsq_pkg::*;
#(
  parameter int LQ_DEPTH  = 4,
  parameter int SQ_DEPTH  = 0,
  parameter int MAX_DEPTH = 6,
  localparam int LQ_N  = (LQ_DEPTH == 0) ? MAX_DEPTH : LQ_DEPTH,
  localparam int SQ_N  = (SQ_DEPTH == 0) ? MAX_DEPTH : SQ_DEPTH,
  localparam int LQ_IW = (LQ_N > 1) ? $clog2(LQ_N) : 1,
  localparam int SQ_IW = (SQ_N > 1) ? $clog2(SQ_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             noalias,
  input  logic             alloc_valid,
  input  logic             alloc_ld,
  input  logic             alloc_st,
  input  logic             alloc_sfx,
  output logic             alloc_ready,
  output logic [LQ_IW-1:0] alloc_lq_slot,
  output logic [SQ_IW-1:0] alloc_sq_slot,
  input  logic             cmp_lq_valid,
  input  logic [LQ_IW-1:0] cmp_lq_slot,
  input  logic             cmp_sq_valid,
  input  logic [SQ_IW-1:0] cmp_sq_slot,
  output logic [LQ_N-1:0]  lq_issue_ok,
  output logic [SQ_N-1:0]  sq_issue_ok,
  output logic             lq_full,
  output logic             sq_full,
  output logic [1:0]       lq_credit_cnt,
  output logic [1:0]       sq_credit_cnt
);

  localparam int AGE_W = $clog2(LQ_N + SQ_N) + 2;

  mem_kind_e kind;
  logic need_lq, need_sq, is_bar, acc;
  logic lq_found, sq_found;
  logic [AGE_W-1:0] age_q;

  logic [LQ_N-1:0]             lq_vld, lq_bar, lq_fb, lq_ret, lq_clr;
  logic [LQ_N-1:0][AGE_W-1:0]  lq_age;
  logic [SQ_N-1:0]             sq_vld, sq_bar, sq_fb, sq_ret, sq_clr;
  logic [SQ_N-1:0][AGE_W-1:0]  sq_age;

  assign kind    = classify(alloc_ld, alloc_st, alloc_sfx);
  assign need_lq = (kind == K_LOAD) || (kind == K_LBAR) || (kind == K_FBAR);
  assign need_sq = (kind == K_STORE) || (kind == K_SBAR) || (kind == K_FBAR);
  assign is_bar  = (kind == K_LBAR) || (kind == K_SBAR) || (kind == K_FBAR);

  lsq_pick #(.N(LQ_N), .IW(LQ_IW)) u_lq_pick (
    .busy(lq_vld), .found(lq_found), .idx(alloc_lq_slot));
  lsq_pick #(.N(SQ_N), .IW(SQ_IW)) u_sq_pick (
    .busy(sq_vld), .found(sq_found), .idx(alloc_sq_slot));

  assign lq_full     = !lq_found;
  assign sq_full     = !sq_found;
  assign alloc_ready = (!need_lq || lq_found) && (!need_sq || sq_found);
  assign acc         = alloc_valid && alloc_ready && (kind != K_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)   age_q <= '0;
    else if (acc) age_q <= age_q + 1'b1;
  end

  for (genvar g = 0; g < LQ_N; g++) begin : g_lq_clr
    assign lq_clr[g] = lq_vld[g] &&
      ((cmp_lq_valid && (cmp_lq_slot == LQ_IW'(g))) || lq_ret[g]);
  end
  for (genvar g = 0; g < SQ_N; g++) begin : g_sq_clr
    assign sq_clr[g] = sq_vld[g] &&
      ((cmp_sq_valid && (cmp_sq_slot == SQ_IW'(g))) || sq_ret[g]);
  end

  assign lq_credit_cnt = 2'($countones(lq_clr));
  assign sq_credit_cnt = 2'($countones(sq_clr));

  lsq_queue #(.N(LQ_N), .AGE_W(AGE_W), .IW(LQ_IW)) u_lq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc && need_lq), .wr_idx(alloc_lq_slot), .wr_age(age_q),
    .wr_bar(is_bar), .wr_full(kind == K_FBAR), .clr(lq_clr),
    .vld(lq_vld), .age(lq_age), .bar(lq_bar), .fullb(lq_fb));

  lsq_queue #(.N(SQ_N), .AGE_W(AGE_W), .IW(SQ_IW)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc && need_sq), .wr_idx(alloc_sq_slot), .wr_age(age_q),
    .wr_bar(is_bar), .wr_full(kind == K_FBAR), .clr(sq_clr),
    .vld(sq_vld), .age(sq_age), .bar(sq_bar), .fullb(sq_fb));

  lsq_rules #(.LQN(LQ_N), .SQN(SQ_N), .AGE_W(AGE_W)) u_rules (
    .clk(clk), .rst_n(rst_n), .noalias(noalias),
    .lq_vld(lq_vld), .lq_age(lq_age), .lq_bar(lq_bar), .lq_fb(lq_fb),
    .sq_vld(sq_vld), .sq_age(sq_age), .sq_bar(sq_bar), .sq_fb(sq_fb),
    .lq_ok(lq_issue_ok), .sq_ok(sq_issue_ok),
    .lq_ret(lq_ret), .sq_ret(sq_ret));

  // A full pool never accepts an op that needs it.
  p_full_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && ((need_lq && lq_full) || (need_sq && sq_full))) |-> !alloc_ready);

  // Each accepted op receives the next age tag.
  p_age_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (age_q == AGE_W'($past(age_q) + 1'b1)));

  // Occupancy drops by the reported credit when nothing is added.
  p_credit_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && need_lq) |=>
      ($countones(lq_vld) == $past($countones(lq_vld)) - $past(int'(lq_credit_cnt))));

endmodule

// File: tb/lsq_order_unit_tb.sv
module lsq_order_unit_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic noalias = 1'b1;
  logic alloc_valid = 1'b0, alloc_ld = 1'b0, alloc_st = 1'b0, alloc_sfx = 1'b0;
  logic alloc_ready;
  logic [1:0] alloc_lq_slot;
  logic [2:0] alloc_sq_slot;
  logic cmp_lq_valid = 1'b0, cmp_sq_valid = 1'b0;
  logic [1:0] cmp_lq_slot = '0;
  logic [2:0] cmp_sq_slot = '0;
  logic [3:0] lq_issue_ok;
  logic [5:0] sq_issue_ok;
  logic lq_full, sq_full;
  logic [1:0] lq_credit_cnt, sq_credit_cnt;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lsq_order_unit u_dut (
    .clk(clk), .rst_n(rst_n), .noalias(noalias),
    .alloc_valid(alloc_valid), .alloc_ld(alloc_ld), .alloc_st(alloc_st),
    .alloc_sfx(alloc_sfx), .alloc_ready(alloc_ready),
    .alloc_lq_slot(alloc_lq_slot), .alloc_sq_slot(alloc_sq_slot),
    .cmp_lq_valid(cmp_lq_valid), .cmp_lq_slot(cmp_lq_slot),
    .cmp_sq_valid(cmp_sq_valid), .cmp_sq_slot(cmp_sq_slot),
    .lq_issue_ok(lq_issue_ok), .sq_issue_ok(sq_issue_ok),
    .lq_full(lq_full), .sq_full(sq_full),
    .lq_credit_cnt(lq_credit_cnt), .sq_credit_cnt(sq_credit_cnt));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    alloc_valid = 1'b0; alloc_ld = 1'b0; alloc_st = 1'b0; alloc_sfx = 1'b0;
    cmp_lq_valid = 1'b0; cmp_sq_valid = 1'b0;
    #1;
  endtask

  task automatic offer(input logic ld, input logic st, input logic sfx);
    alloc_valid = 1'b1; alloc_ld = ld; alloc_st = st; alloc_sfx = sfx;
    #1;
  endtask

  task automatic push(input logic ld, input logic st, input logic sfx);
    offer(ld, st, sfx);
    tick();
  endtask

  task automatic done_lq(input int idx);
    cmp_lq_valid = 1'b1; cmp_lq_slot = 2'(idx);
    #1;
  endtask

  task automatic done_sq(input int idx);
    cmp_sq_valid = 1'b1; cmp_sq_slot = 3'(idx);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    noalias = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8", "reset lq_issue", int'(lq_issue_ok), 0);
    check("R8", "reset sq_issue", int'(sq_issue_ok), 0);
    check("R8", "reset lq_full", int'(lq_full), 0);
    check("R8", "reset sq_full", int'(sq_full), 0);
    check("R8", "idle ready", int'(alloc_ready), 1);
    check("R9", "reset credit", int'(lq_credit_cnt) + int'(sq_credit_cnt), 0);
  endtask

  task automatic t_store_order();
    do_reset();
    push(1, 0, 0); push(0, 1, 0); push(0, 1, 0);
    check("R3", "lone load eligible", int'(lq_issue_ok), 1);
    check("R2", "store behind load", int'(sq_issue_ok), 0);
    done_lq(0);
    check("R9", "completion credit", int'(lq_credit_cnt), 1);
    tick();
    check("R1", "only oldest store", int'(sq_issue_ok), 1);
    done_sq(0);
    check("R9", "store credit", int'(sq_credit_cnt), 1);
    tick();
    check("R1", "next store", int'(sq_issue_ok), 2);
  endtask

  task automatic t_alias();
    do_reset();
    noalias = 1'b0;
    push(0, 1, 0); push(1, 0, 0);
    check("R4", "aliasing load held", int'(lq_issue_ok), 0);
    check("R1", "oldest store free", int'(sq_issue_ok), 1);
    noalias = 1'b1;
    #1;
    check("R4", "noalias load passes", int'(lq_issue_ok), 1);
  endtask

  task automatic t_load_load();
    do_reset();
    push(1, 0, 0); push(1, 0, 0);
    check("R3", "adjacent loads", int'(lq_issue_ok), 3);
    push(0, 1, 0); push(1, 0, 0);
    check("R3", "store between loads", int'(lq_issue_ok), 3);
    done_lq(0); tick();
    check("R3", "still separated", int'(lq_issue_ok), 2);
    done_lq(1); tick();
    check("R4", "load past store", int'(lq_issue_ok), 4);
    check("R2", "store after loads gone", int'(sq_issue_ok), 1);
  endtask

  task automatic t_barriers();
    do_reset();
    push(1, 0, 0);
    offer(1, 0, 1);
    check("R7", "load barrier slot", int'(alloc_lq_slot), 1);
    tick();
    push(1, 0, 0);
    check("R5", "load barrier blocks", int'(lq_issue_ok), 1);
    check("R6", "barrier not oldest", int'(lq_credit_cnt), 0);
    done_lq(0); tick();
    check("R6", "barrier departs", int'(lq_credit_cnt), 1);
    check("R6", "barrier not eligible", int'(lq_issue_ok), 0);
    tick();
    check("R5", "load after barrier", int'(lq_issue_ok), 4);
    push(0, 1, 0); push(0, 1, 1); push(0, 1, 0);
    done_lq(2); tick();
    check("R5", "store barrier blocks", int'(sq_issue_ok), 1);
    done_sq(0); tick();
    check("R6", "store barrier departs", int'(sq_credit_cnt), 1);
    check("R6", "store barrier held", int'(sq_issue_ok), 0);
    tick();
    check("R5", "store after barrier", int'(sq_issue_ok), 4);
  endtask

  task automatic t_full_barrier();
    do_reset();
    push(1, 0, 0);
    offer(1, 1, 1);
    check("R7", "full barrier load slot", int'(alloc_lq_slot), 1);
    check("R7", "full barrier store slot", int'(alloc_sq_slot), 0);
    tick();
    push(0, 1, 0); push(1, 0, 0);
    check("R5", "full barrier load side", int'(lq_issue_ok), 1);
    check("R5", "full barrier store side", int'(sq_issue_ok), 0);
    done_lq(0); tick();
    check("R6", "full barrier lq credit", int'(lq_credit_cnt), 1);
    check("R6", "full barrier sq credit", int'(sq_credit_cnt), 1);
    tick();
    check("R5", "loads released", int'(lq_issue_ok), 4);
    check("R5", "stores released", int'(sq_issue_ok), 2);
    do_reset();
    push(1, 0, 1);
    check("R6", "lone barrier departs", int'(lq_credit_cnt), 1);
    tick();
    check("R6", "lone barrier gone", int'(lq_credit_cnt), 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 4; i++) push(1, 0, 0);
    check("R8", "load pool full", int'(lq_full), 1);
    offer(1, 0, 0);
    check("R8", "load refused", int'(alloc_ready), 0);
    alloc_ld = 1'b0; alloc_st = 1'b1; #1;
    check("R8", "store accepted", int'(alloc_ready), 1);
    tick();
    for (int i = 0; i < 4; i++) push(0, 1, 0);
    check("R8", "five stores not full", int'(sq_full), 0);
    offer(1, 1, 0);
    check("R7", "plain read-write is store", int'(alloc_sq_slot), 5);
    tick();
    check("R8", "six stores full", int'(sq_full), 1);
    offer(0, 0, 1);
    check("R7", "no-access op ready", int'(alloc_ready), 1);
    tick();
    offer(1, 1, 1);
    check("R8", "full barrier refused", int'(alloc_ready), 0);
    tick();
  endtask

  task automatic t_slots();
    do_reset();
    push(1, 0, 0); push(1, 0, 0); push(1, 0, 0);
    done_lq(1); tick();
    offer(1, 0, 0);
    check("R10", "reuse lowest hole", int'(alloc_lq_slot), 1);
    tick();
    offer(1, 0, 0);
    check("R10", "next free slot", int'(alloc_lq_slot), 3);
    tick();
  endtask

  task automatic t_same_cycle();
    do_reset();
    push(1, 0, 0); push(1, 0, 1); push(1, 0, 0);
    done_lq(0); tick();
    done_lq(2);
    check("R9", "completion plus departure", int'(lq_credit_cnt), 2);
    tick();
    check("R9", "pool drained", int'(lq_credit_cnt), 0);
    for (int i = 0; i < 3; i++) push(1, 0, 0);
    check("R9", "three refills not full", int'(lq_full), 0);
    push(1, 0, 0);
    check("R9", "four refills full", int'(lq_full), 1);
  endtask

  initial begin
    t_reset();
    t_store_order();
    t_alias();
    t_load_load();
    t_barriers();
    t_full_barrier();
    t_full();
    t_slots();
    t_same_cycle();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule